// File: doc/BRIEF.md
# Sparse Syndrome Error Lookup

This block is the correction stage of an error-correcting decoder. It receives a wide syndrome together with the word that produced it. It finds the error pattern for that syndrome and flips the affected bits of the word. A table indexed directly by a 32-bit syndrome would need four billion rows. Only a handful of syndrome values can actually occur, so the block stores just those values in a small content-addressable array. Every stored syndrome is compared with the incoming one at the same time. The position of the matching slot then addresses a companion RAM with one error pattern per slot.

The slots are loaded through a write port before decoding starts, or between lookups. Each write fills one slot with a syndrome, its error pattern and a valid flag. Lookups enter with a strobe, one per cycle if needed. Each result leaves exactly two clock edges later and carries a hit flag, the error pattern that was applied and the corrected word.

Top module: `syn_corrector`

## Requirements
- R1: While reset is held, and until the first lookup result after reset, `out_valid`, `out_hit`, `out_pat` and `out_data` are all zero. Every slot is empty after reset.
- R2: A write with `wr_en` high stores `wr_synd` and `wr_pat` in slot `wr_idx` and marks the slot valid. Lookups presented in the following cycle or later see the new contents.
- R3: A lookup hits only when a valid slot holds a syndrome equal to `in_synd` in all SYND_W bits. A single differing bit gives a miss.
- R4: When several valid slots hold the presented syndrome, the slot with the lowest index supplies the error pattern.
- R5: On a miss, `out_hit` is 0, `out_pat` is all zeros and `out_data` equals the received word unchanged.
- R6: On a hit, `out_hit` is 1, `out_pat` is the pattern of the winning slot and `out_data` equals the received word XOR that pattern.
- R7: A result appears with `out_valid` high exactly two rising edges after the lookup strobe was sampled. Lookups in consecutive cycles give results in consecutive cycles, in order.
- R8: A slot that was never written does not match, even for a syndrome of zero. Rewriting a slot replaces its old syndrome, which then no longer matches that slot.
- R9: When `out_valid` is low, `out_hit`, `out_pat` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | IDX_W (4) | Slot to write |
| wr_synd | input | SYND_W (32) | Syndrome to store |
| wr_pat | input | DATA_W (32) | Error pattern to store |
| in_valid | input | 1 | Lookup strobe |
| in_synd | input | SYND_W (32) | Syndrome to look up |
| in_data | input | DATA_W (32) | Received word |
| out_valid | output | 1 | Result strobe, two edges after `in_valid` |
| out_hit | output | 1 | A valid slot matched |
| out_pat | output | DATA_W (32) | Applied error pattern, zero on a miss |
| out_data | output | DATA_W (32) | Corrected word |

## Verification
Lookups are tried first against an empty array, including a zero syndrome. This separates the valid flags from the stored syndrome bits. Exact hits are contrasted with syndromes that differ from a stored one in a single bit, which shows that every bit takes part in the compare. Two slots loaded with the same syndrome tell a lowest-index winner from any other choice. A back-to-back stream with hits and misses mixed shows the fixed latency and the ordering of results. A slot rewritten and then looked up in the very next cycle shows that the old syndrome is replaced and that the new contents are visible at once.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int MAX_SLOTS = 64;

  // Position of the lowest set bit among the first n bits of v.
  function automatic int lowest_set(input logic [MAX_SLOTS-1:0] v, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Correction of a word by a pattern, gated by the hit flag.
  function automatic logic [MAX_SLOTS-1:0] apply_fix(input logic [MAX_SLOTS-1:0] word,
                                                     input logic [MAX_SLOTS-1:0] pat,
                                                     input logic hit);
    return hit ? (word ^ pat) : word;
  endfunction
endpackage

// File: rtl/syn_cam.sv
module syn_cam #(
  parameter int SLOTS  = 16,
  parameter int SYND_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SYND_W-1:0] wr_synd,
  input  logic [SYND_W-1:0] look_synd,
  output logic [SLOTS-1:0]  match_vec,
  output logic [SLOTS-1:0]  slot_valid
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [SYND_W-1:0] key_q;
    logic              sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_valid[g] <= 1'b0;
      else if (sel) slot_valid[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) key_q <= wr_synd;
    end

    assign match_vec[g] = slot_valid[g] && (key_q == look_synd);
  end
endmodule

// File: rtl/syn_pat_ram.sv
module syn_pat_ram #(
  parameter int SLOTS = 16,
  parameter int PAT_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PAT_W-1:0] wr_pat,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PAT_W-1:0] rd_pat
);
  logic [PAT_W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_pat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_pat <= '0;
    else if (rd_en) rd_pat <= mem[rd_idx];
    else            rd_pat <= '0;
  end
endmodule

// File: rtl/syn_corrector.sv
module syn_corrector #(
  parameter int SLOTS  = 16,
  parameter int SYND_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SYND_W-1:0] wr_synd,
  input  logic [DATA_W-1:0] wr_pat,
  input  logic              in_valid,
  input  logic [SYND_W-1:0] in_synd,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_hit,
  output logic [DATA_W-1:0] out_pat,
  output logic [DATA_W-1:0] out_data
);
  import syn_pkg::*;

  logic [SLOTS-1:0]  match_vec;
  logic [SLOTS-1:0]  slot_valid;
  logic              any_match;
  logic [IDX_W-1:0]  win_idx;
  logic              s1_valid, s1_hit;
  logic [IDX_W-1:0]  s1_idx;
  logic [DATA_W-1:0] s1_data;
  logic [DATA_W-1:0] s2_data;
  logic [DATA_W-1:0] rd_pat;
  logic [MAX_SLOTS-1:0] match_wide;
  logic [MAX_SLOTS-1:0] fixed_wide;

  syn_cam #(.SLOTS(SLOTS), .SYND_W(SYND_W)) i_cam (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_synd(wr_synd),
    .look_synd(in_synd), .match_vec(match_vec), .slot_valid(slot_valid)
  );

  assign match_wide = MAX_SLOTS'(match_vec);
  assign any_match  = |match_vec;
  assign win_idx    = IDX_W'(lowest_set(match_wide, SLOTS));

  // Stage 1: match result registered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_idx   <= '0;
      s1_data  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_hit   <= in_valid && any_match;
      s1_idx   <= win_idx;
      s1_data  <= in_valid ? in_data : '0;
    end
  end

  syn_pat_ram #(.SLOTS(SLOTS), .PAT_W(DATA_W)) i_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pat(wr_pat),
    .rd_en(s1_hit), .rd_idx(s1_idx), .rd_pat(rd_pat)
  );

  // Stage 2: pattern read alongside flags and word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      s2_data   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_hit   <= s1_hit;
      s2_data   <= s1_data;
    end
  end

  assign fixed_wide = apply_fix(MAX_SLOTS'(s2_data), MAX_SLOTS'(rd_pat), out_hit);
  assign out_pat    = rd_pat;
  assign out_data   = fixed_wide[DATA_W-1:0];
endmodule

// File: rtl/syn_corrector_chk.sv
module syn_corrector_chk #(
  parameter int SLOTS  = 16,
  parameter int SYND_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_hit,
  input logic [DATA_W-1:0] out_pat,
  input logic [DATA_W-1:0] out_data,
  input logic [SLOTS-1:0]  match_vec,
  input logic [SLOTS-1:0]  slot_valid,
  input logic              s1_hit
);
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));
  // R5
  miss_zero_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |-> out_pat == '0);
  // R6
  corrected_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == ($past(in_data, 2) ^ out_pat));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_hit && out_data == '0));
  // R3
  no_match_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && match_vec == '0) |=> !s1_hit);
  // R2
  write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_valid[$past(wr_idx)]);
  // R8
  empty_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~slot_valid) == '0);
endmodule

bind syn_corrector syn_corrector_chk #(.SLOTS(SLOTS), .SYND_W(SYND_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .in_valid(in_valid),
  .in_data(in_data), .out_valid(out_valid), .out_hit(out_hit), .out_pat(out_pat),
  .out_data(out_data), .match_vec(match_vec), .slot_valid(slot_valid), .s1_hit(s1_hit)
);

// File: tb/test_syn_corrector.sv
module test_syn_corrector;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 16;
  localparam int SW = 32;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_idx = 0;
  logic [SW-1:0] wr_synd = 0;
  logic [DW-1:0] wr_pat = 0;
  logic in_valid = 0;
  logic [SW-1:0] in_synd = 0;
  logic [DW-1:0] in_data = 0;
  logic out_valid, out_hit;
  logic [DW-1:0] out_pat, out_data;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  // Reference state
  bit          m_val [SLOTS];
  logic [SW-1:0] m_key [SLOTS];
  logic [DW-1:0] m_pat [SLOTS];
  bit e1_v, e1_h; int e1_i; logic [DW-1:0] e1_d;
  bit e2_v, e2_h; logic [DW-1:0] e2_p, e2_d;

  syn_corrector i_syn_corrector (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_synd(wr_synd),
    .wr_pat(wr_pat), .in_valid(in_valid), .in_synd(in_synd), .in_data(in_data),
    .out_valid(out_valid), .out_hit(out_hit), .out_pat(out_pat), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      e1_v = 0; e1_h = 0; e1_i = 0; e1_d = 0;
      e2_v = 0; e2_h = 0; e2_p = 0; e2_d = 0;
      foreach (m_val[k]) m_val[k] = 0;
    end else begin
      e2_v = e1_v; e2_h = e1_h;
      e2_p = e1_h ? m_pat[e1_i] : '0;
      e2_d = e1_v ? (e1_d ^ e2_p) : '0;
      e1_v = in_valid; e1_h = 0; e1_i = 0; e1_d = in_valid ? in_data : '0;
      if (in_valid) begin
        for (int k = SLOTS - 1; k >= 0; k--)
          if (m_val[k] && m_key[k] == in_synd) begin e1_h = 1; e1_i = k; end
      end
      if (wr_en) begin
        m_val[wr_idx] = 1; m_key[wr_idx] = wr_synd; m_pat[wr_idx] = wr_pat;
      end
    end
  end

  task automatic cmp(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare every output against the reference, away from the active edge.
  always @(negedge clk) if (rst_n) begin
    cmp("valid", DW'(out_valid), DW'(e2_v));
    cmp("hit",   DW'(out_hit),   DW'(e2_h));
    cmp("pat",   out_pat,        e2_p);
    cmp("data",  out_data,       e2_d);
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 0; in_valid = 0; in_synd = 0; in_data = 0;
  endtask

  task automatic wr(input int idx, input logic [SW-1:0] s, input logic [DW-1:0] p);
    @(negedge clk);
    in_valid = 0;
    wr_en = 1; wr_idx = 4'(idx); wr_synd = s; wr_pat = p;
  endtask

  task automatic look(input logic [SW-1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 0;
    in_valid = 1; in_synd = s; in_data = d;
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp("reset valid", DW'(out_valid), 0);
    cmp("reset hit", DW'(out_hit), 0);
    cmp("reset pat", out_pat, 0);
    cmp("reset data", out_data, 0);
    rst_n = 1;
    idle();
    tag = "R8"; look(32'h0, 32'hA5A5_0001); look(32'h1234_5678, 32'h0F0F_0F0F); drain();
    tag = "R2";
    for (int k = 0; k < SLOTS; k++) wr(k, 32'h1000_0000 + 32'(k * 32'h0101_0101), 32'h1 << k);
    idle();
    tag = "R6";
    for (int k = 0; k < SLOTS; k += 3) look(32'h1000_0000 + 32'(k * 32'h0101_0101), 32'hCAFE_0000 + 32'(k));
    drain();
    // R6: directed check of one hit, sampled two edges after the strobe
    look(32'h1000_0000 + 32'(2 * 32'h0101_0101), 32'hFFFF_FFFF); idle(); @(negedge clk);
    cmp("direct hit R6", out_data, 32'hFFFF_FFFB);
    drain();
    tag = "R3";
    look(32'h1000_0000 ^ 32'h8000_0000, 32'h1111_1111);
    look((32'h1000_0000 + 32'h0505_0505) ^ 32'h1, 32'h2222_2222);
    look(32'h1000_0000 + 32'h0505_0505, 32'h2222_2222);
    drain();
    tag = "R5";
    look(32'hDEAD_BEEF, 32'h1357_9BDF); idle(); @(negedge clk);
    cmp("miss passthrough R5", out_data, 32'h1357_9BDF);
    drain();
    tag = "R4";
    wr(3, 32'h00AB_CDEF, 32'h0000_0030); wr(9, 32'h00AB_CDEF, 32'h0000_0900); idle();
    look(32'h00AB_CDEF, 32'h0); idle(); @(negedge clk);
    cmp("lowest slot pattern R4", out_pat, 32'h0000_0030);
    drain();
    tag = "R7";
    for (int k = 0; k < 20; k++)
      look((k % 2 == 0) ? 32'h1000_0000 + 32'((k % SLOTS) * 32'h0101_0101) : 32'hFFFF_0000 + 32'(k),
           32'h5000_0000 + 32'(k * 7));
    drain();
    tag = "R8";
    wr(5, 32'h7777_7777, 32'hF000_000F);
    look(32'h7777_7777, 32'h0000_FFFF);
    look(32'h1000_0000 + 32'h0505_0505, 32'h0000_FFFF);
    drain();
    tag = "R9"; drain();
    cmp("idle hit R9", DW'(out_hit), 0);
    cmp("idle data R9", out_data, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    errors++;
    $display("FAIL watchdog: actual %0d expected below 5000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule